// File: doc/BRIEF.md
# Compressed Symmetric Substitution Score Table

This block holds the pairwise substitution scores for a 20-letter protein alphabet and returns the score for any pair of symbol codes. It feeds an alignment datapath. A full two-dimensional table indexed by two 5-bit codes would need 1024 words, and most of them would never be used. This table keeps only 336 words.

Each symbol code is split on its top bit. Codes 0x00 to 0x0F are the low group and codes 0x10 to 0x13 are the high group. A pair that falls inside one group keeps both orientations, because each orientation has its own word. A pair with one low code and one high code is stored once and serves both orientations, since the score matrix is symmetric.

The host loads scores through a write port that takes a symbol pair, not a raw address. The same encoder maps write pairs and read pairs. The read result is registered. It is given in sign-magnitude form and also converted to two's complement for arithmetic downstream.

Top module: `subst_lookup`

## Requirements
- R1: While reset is asserted and after it is released, `score_sm`, `score_tc` and `sym_err` are all zero until the first read is accepted.
- R2: When `rd_en` is high at a rising edge, the outputs at that edge take the score of the pair (`rd_sym_a`, `rd_sym_b`). The read has one cycle of latency.
- R3: A write to a pair with one code in 0x00–0x0F and the other in 0x10–0x13 is returned by a read of either orientation of that pair.
- R4: Inside one group (both codes below 0x10, or both from 0x10 to 0x13), the pairs (a,b) and (b,a) are separate entries. Writing one of them leaves the other unchanged.
- R5: `score_sm` is 9-bit sign-magnitude: bit 8 is the sign (1 means negative) and bits 7:0 are the magnitude. `score_tc` holds the same value in 9-bit two's complement, so a negative zero gives 0.
- R6: A read with any code at 0x14 or above returns `score_sm` = 0 and `score_tc` = 0 with `sym_err` = 1. A read where both codes are valid gives `sym_err` = 0.
- R7: A write with any code at 0x14 or above changes no stored score, including the entry its low code bits would alias to.
- R8: While `rd_en` is low, all three outputs hold their values, whatever the symbol inputs do.
- R9: A read and a write to the same pair in the same cycle return the score stored before that write. The new score is seen from the next read.
- R10: Every one of the 336 words is reachable, and a valid pair never maps outside them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside the block |
| wr_en | input | 1 | Write strobe for one score |
| wr_sym_a | input | 5 | First symbol code of the pair being written |
| wr_sym_b | input | 5 | Second symbol code of the pair being written |
| wr_score | input | 9 | Score to store, sign-magnitude |
| rd_en | input | 1 | Read enable; updates the outputs |
| rd_sym_a | input | 5 | First symbol code of the pair looked up |
| rd_sym_b | input | 5 | Second symbol code of the pair looked up |
| score_sm | output | 9 | Registered score, sign-magnitude |
| score_tc | output | 9 | Registered score, two's complement |
| sym_err | output | 1 | Registered flag: the last accepted read had an out-of-range code |

## Verification
A wrong entry or a faulty address map shows at the score outputs exactly one cycle after a read of the affected pair. It stays hidden until that pair is read. For that reason the bench first loads every ordered pair and then reads the table back many times in random order. If two pairs alias, the second write overwrites the first. That mismatch appears only when the earlier pair is read back, so the cross-group and same-group orientations are written with different values. A failure in output formatting or error handling shows in the same cycle as the score. These faults are caught by out-of-range reads, the negative-zero case and the extreme magnitudes.

// File: rtl/subst_pkg.sv
package subst_pkg;
  localparam int unsigned SUBST_SYM_W   = 5;
  localparam int unsigned SUBST_NUM_SYM = 20;
  localparam int unsigned SUBST_SCORE_W = 9;

  typedef enum logic [1:0] {
    QUAD_LL = 2'd0,
    QUAD_LH = 2'd1,
    QUAD_HH = 2'd2
  } quad_e;
endpackage

// File: rtl/subst_rst_sync.sv
module subst_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/subst_addr_enc.sv
module subst_addr_enc
  import subst_pkg::*;
#(
  parameter int unsigned SYM_W   = SUBST_SYM_W,
  parameter int unsigned NUM_SYM = SUBST_NUM_SYM,
  parameter int unsigned LOW_W   = SYM_W - 1,
  parameter int unsigned NUM_UP  = NUM_SYM - (2 ** LOW_W),
  parameter int unsigned UP_W    = $clog2(NUM_UP),
  parameter int unsigned BASE_LH = 2 ** (2 * LOW_W),
  parameter int unsigned BASE_HH = BASE_LH + (2 ** UP_W) * (2 ** LOW_W),
  parameter int unsigned DEPTH   = BASE_HH + 2 ** (2 * UP_W),
  parameter int unsigned ADDR_W  = $clog2(DEPTH)
) (
  input  logic [SYM_W-1:0]  sym_a,
  input  logic [SYM_W-1:0]  sym_b,
  output logic [ADDR_W-1:0] addr,
  output logic              in_range
);
  localparam logic [SYM_W-1:0]  SYM_LIMIT = SYM_W'(NUM_SYM);
  localparam logic [ADDR_W-1:0] OFS_LH    = ADDR_W'(BASE_LH);
  localparam logic [ADDR_W-1:0] OFS_HH    = ADDR_W'(BASE_HH);

  logic             swap;
  logic [SYM_W-1:0] lo_sym;
  logic [SYM_W-1:0] hi_sym;
  quad_e            quad;

  always_comb begin
    in_range = (sym_a < SYM_LIMIT) && (sym_b < SYM_LIMIT);
    // the high-low quadrant is folded onto the low-high one
    swap   = sym_a[SYM_W-1] & ~sym_b[SYM_W-1];
    lo_sym = swap ? sym_b : sym_a;
    hi_sym = swap ? sym_a : sym_b;
    if (lo_sym[SYM_W-1] && hi_sym[SYM_W-1]) begin
      quad = QUAD_HH;
    end else if (hi_sym[SYM_W-1]) begin
      quad = QUAD_LH;
    end else begin
      quad = QUAD_LL;
    end
    unique case (quad)
      QUAD_LL: addr = ADDR_W'({lo_sym[LOW_W-1:0], hi_sym[LOW_W-1:0]});
      QUAD_LH: addr = OFS_LH + ADDR_W'({hi_sym[UP_W-1:0], lo_sym[LOW_W-1:0]});
      QUAD_HH: addr = OFS_HH + ADDR_W'({lo_sym[UP_W-1:0], hi_sym[UP_W-1:0]});
      default: addr = '0;
    endcase
  end
endmodule

// File: rtl/subst_store.sv
module subst_store #(
  parameter int unsigned DEPTH  = 336,
  parameter int unsigned ADDR_W = $clog2(DEPTH),
  parameter int unsigned DATA_W = 9
) (
  input  logic              clk,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic [DATA_W-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_req && (wr_addr <= LAST)) begin
      words[wr_addr] <= wr_data;
    end
  end

  always_comb begin
    if (rd_addr <= LAST) begin
      rd_data = words[rd_addr];
    end else begin
      rd_data = '0;
    end
  end
endmodule

// File: rtl/subst_fmt.sv
module subst_fmt #(
  parameter int unsigned SCORE_W = 9
) (
  input  logic [SCORE_W-1:0] sm_in,
  output logic [SCORE_W-1:0] tc_out
);
  logic [SCORE_W-1:0] mag;

  always_comb begin
    mag    = {1'b0, sm_in[SCORE_W-2:0]};
    tc_out = sm_in[SCORE_W-1] ? (~mag + 1'b1) : mag;
  end
endmodule

// File: rtl/subst_lookup.sv
module subst_lookup
  import subst_pkg::*;
#(
  parameter int unsigned SYM_W   = SUBST_SYM_W,
  parameter int unsigned NUM_SYM = SUBST_NUM_SYM,
  parameter int unsigned SCORE_W = SUBST_SCORE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [SYM_W-1:0]   wr_sym_a,
  input  logic [SYM_W-1:0]   wr_sym_b,
  input  logic [SCORE_W-1:0] wr_score,
  input  logic               rd_en,
  input  logic [SYM_W-1:0]   rd_sym_a,
  input  logic [SYM_W-1:0]   rd_sym_b,
  output logic [SCORE_W-1:0] score_sm,
  output logic [SCORE_W-1:0] score_tc,
  output logic               sym_err
);
  localparam int unsigned LOW_W   = SYM_W - 1;
  localparam int unsigned NUM_UP  = NUM_SYM - (2 ** LOW_W);
  localparam int unsigned UP_W    = $clog2(NUM_UP);
  localparam int unsigned BASE_LH = 2 ** (2 * LOW_W);
  localparam int unsigned BASE_HH = BASE_LH + (2 ** UP_W) * (2 ** LOW_W);
  localparam int unsigned DEPTH   = BASE_HH + 2 ** (2 * UP_W);
  localparam int unsigned ADDR_W  = $clog2(DEPTH);
  localparam int unsigned NPORT   = 2;
  localparam int unsigned RD_P    = 0;
  localparam int unsigned WR_P    = 1;

  logic rst_sync_n;

  subst_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk      (clk),
    .rst_n_in (rst_n),
    .rst_n_out(rst_sync_n)
  );

  logic [SYM_W-1:0]  enc_a    [NPORT];
  logic [SYM_W-1:0]  enc_b    [NPORT];
  logic [ADDR_W-1:0] enc_addr [NPORT];
  logic              enc_ok   [NPORT];

  assign enc_a[RD_P] = rd_sym_a;
  assign enc_b[RD_P] = rd_sym_b;
  assign enc_a[WR_P] = wr_sym_a;
  assign enc_b[WR_P] = wr_sym_b;

  for (genvar p = 0; p < NPORT; p++) begin : g_enc
    subst_addr_enc #(
      .SYM_W  (SYM_W),
      .NUM_SYM(NUM_SYM)
    ) i_enc (
      .sym_a   (enc_a[p]),
      .sym_b   (enc_b[p]),
      .addr    (enc_addr[p]),
      .in_range(enc_ok[p])
    );
  end

  logic [SCORE_W-1:0] stored;

  subst_store #(
    .DEPTH (DEPTH),
    .ADDR_W(ADDR_W),
    .DATA_W(SCORE_W)
  ) i_store (
    .clk    (clk),
    .wr_req (wr_en && enc_ok[WR_P]),
    .wr_addr(enc_addr[WR_P]),
    .wr_data(wr_score),
    .rd_addr(enc_addr[RD_P]),
    .rd_data(stored)
  );

  logic [SCORE_W-1:0] score_q, score_d;
  logic               err_q, err_d;

  always_comb begin
    score_d = score_q;
    err_d   = err_q;
    if (rd_en) begin
      score_d = enc_ok[RD_P] ? stored : '0;
      err_d   = ~enc_ok[RD_P];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      score_q <= '0;
      err_q   <= 1'b0;
    end else begin
      score_q <= score_d;
      err_q   <= err_d;
    end
  end

  subst_fmt #(.SCORE_W(SCORE_W)) i_fmt (
    .sm_in (score_q),
    .tc_out(score_tc)
  );

  assign score_sm = score_q;
  assign sym_err  = err_q;

  // R6
  bad_sym_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_en && !enc_ok[RD_P]) |=> (score_sm == '0 && sym_err));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rd_en |=> ($stable(score_sm) && $stable(sym_err)));

  // R5
  tc_sign_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (score_sm[SCORE_W-1] && (score_sm[SCORE_W-2:0] != '0)) |-> score_tc[SCORE_W-1]);

  // R5
  tc_pos_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !score_sm[SCORE_W-1] |-> (score_tc == score_sm));

  // R3
  cross_share_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (enc_ok[RD_P] && enc_ok[WR_P] && rd_sym_a == wr_sym_b && rd_sym_b == wr_sym_a
     && rd_sym_a[SYM_W-1] != rd_sym_b[SYM_W-1])
    |-> (enc_addr[RD_P] == enc_addr[WR_P]));

  // R4
  same_group_split_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (enc_ok[RD_P] && enc_ok[WR_P] && rd_sym_a == wr_sym_b && rd_sym_b == wr_sym_a
     && rd_sym_a != rd_sym_b && rd_sym_a[SYM_W-1] == rd_sym_b[SYM_W-1])
    |-> (enc_addr[RD_P] != enc_addr[WR_P]));

  // R10
  addr_span_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    enc_ok[RD_P] |-> (enc_addr[RD_P] < ADDR_W'(DEPTH)));
endmodule

// File: tb/test_subst_lookup.sv
`timescale 1ns/1ps
module test_subst_lookup;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [4:0] wr_sym_a = '0;
  logic [4:0] wr_sym_b = '0;
  logic [8:0] wr_score = '0;
  logic       rd_en = 1'b0;
  logic [4:0] rd_sym_a = '0;
  logic [4:0] rd_sym_b = '0;
  logic [8:0] score_sm;
  logic [8:0] score_tc;
  logic       sym_err;

  int checks = 0;
  int failures = 0;
  logic [8:0] ref_tab [20][20];

  always #2.5 clk = ~clk;

  subst_lookup i_subst_lookup (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_sym_a(wr_sym_a), .wr_sym_b(wr_sym_b), .wr_score(wr_score),
    .rd_en(rd_en), .rd_sym_a(rd_sym_a), .rd_sym_b(rd_sym_b),
    .score_sm(score_sm), .score_tc(score_tc), .sym_err(sym_err)
  );

  function automatic bit bad_code(int a, int b);
    return (a >= 20) || (b >= 20);
  endfunction

  function automatic logic [8:0] exp_sm(int a, int b);
    if (bad_code(a, b)) return 9'd0;
    return ref_tab[a][b];
  endfunction

  function automatic logic [8:0] exp_tc(logic [8:0] sm);
    logic signed [31:0] v;
    v = $signed({24'd0, sm[7:0]});
    if (sm[8]) v = -v;
    return v[8:0];
  endfunction

  task automatic report(bit ok, string req, string what);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: got sm=%h tc=%h err=%b", req, what, score_sm, score_tc, sym_err);
    end
  endtask

  task automatic do_write(int a, int b, logic [8:0] s);
    @(negedge clk);
    wr_en = 1'b1; wr_sym_a = a[4:0]; wr_sym_b = b[4:0]; wr_score = s;
    @(negedge clk);
    wr_en = 1'b0;
    if (!bad_code(a, b)) begin
      ref_tab[a][b] = s;
      if ((a >= 16) != (b >= 16)) ref_tab[b][a] = s;
    end
  endtask

  task automatic do_read(int a, int b, string req);
    logic [8:0] e;
    logic ee;
    e = exp_sm(a, b);
    ee = bad_code(a, b);
    @(negedge clk);
    rd_en = 1'b1; rd_sym_a = a[4:0]; rd_sym_b = b[4:0];
    @(negedge clk);
    rd_en = 1'b0;
    report(score_sm == e && score_tc == exp_tc(e) && sym_err == ee, req,
           $sformatf("pair (%0h,%0h) expected sm=%h tc=%h err=%b", a, b, e, exp_tc(e), ee));
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 outputs during reset
    report(score_sm == 0 && score_tc == 0 && sym_err == 0, "R1", "in reset expected all zero");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    report(score_sm == 0 && score_tc == 0 && sym_err == 0, "R1", "after release expected all zero");

    // load every ordered pair (R4 orientations differ, R3 cross pairs shared)
    for (int a = 0; a < 20; a++) begin
      for (int b = 0; b < 20; b++) begin
        do_write(a, b, 9'($urandom));
      end
    end

    // R2 full sweep
    for (int a = 0; a < 20; a++) begin
      for (int b = 0; b < 20; b++) begin
        do_read(a, b, "R2");
      end
    end

    // R3 one write serves both orientations
    do_write(5'h11, 5'h04, 9'h02B);
    do_read(5'h04, 5'h11, "R3");
    do_read(5'h11, 5'h04, "R3");
    do_write(5'h02, 5'h13, 9'h1C4);
    do_read(5'h13, 5'h02, "R3");

    // R4 same-group orientations are separate
    do_write(2, 5, 9'h007);
    do_write(5, 2, 9'h103);
    do_read(2, 5, "R4");
    do_read(5, 2, "R4");
    do_write(5'h10, 5'h12, 9'h055);
    do_write(5'h12, 5'h10, 9'h1AA);
    do_read(5'h10, 5'h12, "R4");
    do_read(5'h12, 5'h10, "R4");

    // R5 format corners
    do_write(1, 1, 9'h100);
    do_read(1, 1, "R5");
    do_write(3, 3, 9'h1FF);
    do_read(3, 3, "R5");
    do_write(4, 4, 9'h0FF);
    do_read(4, 4, "R5");

    // R6 out-of-range reads
    do_read(5'h14, 3, "R6");
    do_read(7, 5'h1F, "R6");
    do_read(5'h15, 5'h17, "R6");

    // R7 invalid writes must not touch the aliased entries
    do_write(5'h14, 5'h03, 9'h0AB);
    do_read(5'h03, 5'h10, "R7");
    do_read(5'h10, 5'h03, "R7");
    do_write(5'h1F, 5'h1F, 9'h0CD);
    do_read(5'h13, 5'h13, "R7");
    do_write(5'h0E, 5'h18, 9'h0EE);
    do_read(5'h0E, 5'h10, "R7");

    // R8 hold while not reading
    do_read(5, 9, "R8");
    @(negedge clk);
    rd_sym_a = 5'h01; rd_sym_b = 5'h1E;
    repeat (3) @(negedge clk);
    report(score_sm == exp_sm(5, 9) && sym_err == 1'b0, "R8", "hold after valid read");
    do_read(5'h1D, 2, "R8");
    @(negedge clk);
    rd_sym_a = 5'h00; rd_sym_b = 5'h00;
    repeat (3) @(negedge clk);
    report(score_sm == 0 && sym_err == 1'b1, "R8", "hold after bad read");

    // R9 read and write to the same pair in one cycle
    begin
      logic [8:0] old_v;
      old_v = exp_sm(3, 7);
      @(negedge clk);
      wr_en = 1'b1; wr_sym_a = 5'd3; wr_sym_b = 5'd7; wr_score = ~old_v;
      rd_en = 1'b1; rd_sym_a = 5'd3; rd_sym_b = 5'd7;
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
      report(score_sm == old_v && score_tc == exp_tc(old_v), "R9", "collision read expected old value");
      ref_tab[3][7] = ~old_v;
      do_read(3, 7, "R9");
    end

    // random mix of writes and reads, includes out-of-range codes (R10 span)
    for (int i = 0; i < 800; i++) begin
      int a;
      int b;
      a = int'($urandom_range(0, 23));
      b = int'($urandom_range(0, 23));
      if ($urandom_range(0, 3) == 0) begin
        do_write(a, b, 9'($urandom));
      end else begin
        do_read(a, b, "R10");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule